// File: doc/BRIEF.md
# Serial Command Decoder and Channel Sequencer

This block sits behind a byte-level two-wire bus slave and turns the first byte of a transaction into control for an analog front end. The byte carries a 4-bit identity field, an operation bit that chooses between running a conversion and accessing the alarm-limit store, a 2-bit channel field and a direction bit. When the identity matches, the block acknowledges the byte, latches the fields, and then drives a multiplexer index, a sample-enable level and a one-cycle conversion-start pulse. The timing of these comes from the bus clock edges that the front end reports as single-cycle strobes.

Four conversion patterns follow from the byte and the host's behaviour. A read that stops after one word is a single conversion. A read that keeps acknowledging words on a fixed channel repeats that channel. A read with channel field 11 walks through the channels. A conversion command with the direction bit clear starts autonomous monitoring, which runs on the converter's done strobe until a new matching command arrives. Two straps choose the variant: a channel-count strap sets the wrap point, and an addressing strap replaces the fixed identity with three address pins plus a trailing 1, gated by an active-low enable pin.

States: IDLE (no command), ACK (acknowledge clock of an accepted command), GAP (sample still open, waiting for the next SCL rise), XFER (data phase), RESAMP (acknowledge clock of a word read by the host, sample reopened), MSAMP (monitor sample and start), MCONV (monitor waiting for done). Transitions: accept (matching byte, any state to ACK), ack_end (SCL fall in ACK to GAP, XFER or MSAMP), hold (SCL rise in GAP to XFER), word_more (host acknowledged a conversion word, XFER to RESAMP), resample_end (SCL fall in RESAMP to GAP), mon_start (MSAMP to MCONV), mon_done (done strobe, MCONV to MSAMP), stop (bus stop, any non-monitor state to IDLE).

Top module: `scd_top`

## Requirements
- R1: Byte bits [7:4] must equal 1001 when `var_addr` is 0, or {`addr_pins`, 1} when `var_addr` is 1 and `ce_n` is 0. Any other byte on `cmd_valid` is ignored: `cmd_ack` stays low and every output and all state keep their values.
- R2: `cmd_ack` goes high in the cycle after a matching byte is accepted. It stays high until the first `scl_fall` (the end of the acknowledge clock) or `bus_stop`, whichever comes first.
- R3: Byte bit 3 is the operation bit (0 = conversion, 1 = limit store). Bits [2:1] are the channel field. For field values 00, 01 and 10, `mux_sel` becomes 0, 1 and 2 one cycle after the byte is accepted. `mux_sel` changes only on an accept, a host word acknowledge or a converter done.
- R4: A conversion command (bit 3 = 0) with channel field 11 selects auto-increment and sets `mux_sel` to 0.
- R5: In auto-increment mode the channel advances by one on each step and wraps to 0 after channel 2 when `var_three` is 1, or after channel 1 when `var_three` is 0.
- R6: For a conversion command, `sample_en` is high from the cycle after acceptance until the first `scl_rise` after the acknowledge clock ends. `conv_start` pulses for exactly one cycle on that `scl_rise`, and `sample_en` is low in the following cycle.
- R7: Byte bit 0 = 1 selects read. During the data phase of a read, `rd_shift` is high exactly in the cycles where `scl_fall` is high.
- R8: In a conversion read, each `word_ack` reopens the sample window on the current channel (or on the next channel in auto-increment mode). That window closes with a new `conv_start` on the next `scl_rise` after the following `scl_fall`.
- R9: A limit-store command never raises `sample_en` or `conv_start`. During its data phase `lim_access` is high, and `lim_write` is high when bit 0 is 0. `word_ack` does not change its channel.
- R10: A conversion command with bit 0 = 0 enters monitoring after the acknowledge clock. Monitoring gives a one-cycle sample-and-start, waits for `conv_done`, advances the channel in auto-increment mode, and repeats. `bus_stop` and non-matching bytes do not end it. A matching byte does.
- R11: Outside monitoring, `bus_stop` returns the block to idle with all strobes low.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_byte | input | 8 | Received address/command byte |
| cmd_valid | input | 1 | Strobe: cmd_byte holds a freshly received first byte |
| scl_rise | input | 1 | Strobe: SCL rising edge seen |
| scl_fall | input | 1 | Strobe: SCL falling edge seen |
| bus_stop | input | 1 | Strobe: stop condition seen |
| word_ack | input | 1 | Strobe: host acknowledged a read word |
| conv_done | input | 1 | Strobe: converter finished |
| var_three | input | 1 | Strap: 1 = three channels, 0 = two channels |
| var_addr | input | 1 | Strap: 1 = identity taken from address pins |
| addr_pins | input | 3 | Address pins for the addressable variant |
| ce_n | input | 1 | Active-low enable for the addressable variant |
| cmd_ack | output | 1 | Acknowledge the command byte |
| mux_sel | output | 2 | Channel multiplexer index / limit register select |
| sample_en | output | 1 | Sample-and-hold tracking |
| conv_start | output | 1 | One-cycle conversion request |
| rd_shift | output | 1 | Shift next read bit out |
| lim_access | output | 1 | Limit store being accessed |
| lim_write | output | 1 | Limit store access is a write |
| monitor_on | output | 1 | Autonomous monitoring running |

## Verification
The checker covers the rules that hold in every cycle. A start pulse must fall inside an open sample window and last one cycle. The acknowledge only rises after a byte strobe and holds until a falling edge or stop. The multiplexer index moves only on an accept, a word acknowledge or a done strobe. Limit access keeps the sampler quiet, and monitoring survives anything but a new byte. The bench's scenarios are needed for the ordering behaviour: which identity the straps and enable pin accept, where auto-increment wraps on each variant, that repeated reads keep their channel, and that a stop ends a read but not monitoring.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 4;
    localparam int CODE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_GAP,
        ST_XFER,
        ST_RESAMP,
        ST_MSAMP,
        ST_MCONV
    } seq_state_e;

    typedef struct packed {
        logic              lim;
        logic [CODE_W-1:0] code;
        logic              rd;
        logic              auto_req;
    } cmd_fields_t;

endpackage

// File: rtl/scd_decode.sv
`timescale 1ns/1ps
module scd_decode
    import scd_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_FIXED = 4'b1001
) (
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              var_addr,
    input  logic [ID_W-2:0]   addr_pins,
    input  logic              ce_n,
    output logic              id_hit,
    output cmd_fields_t       fields
);

    localparam logic [CODE_W-1:0] CODE_AUTO = '1;

    logic [ID_W-1:0] exp_id;

    always_comb begin
        exp_id          = var_addr ? {addr_pins, 1'b1} : ID_FIXED;
        id_hit          = (cmd_byte[BYTE_W-1 -: ID_W] == exp_id) && (!var_addr || !ce_n);
        fields.lim      = cmd_byte[3];
        fields.code     = cmd_byte[2:1];
        fields.rd       = cmd_byte[0];
        fields.auto_req = !cmd_byte[3] && (cmd_byte[2:1] == CODE_AUTO);
    end

endmodule

// File: rtl/scd_chan_seq.sv
`timescale 1ns/1ps
module scd_chan_seq
    import scd_pkg::*;
#(
    parameter int CH_W      = 2,
    parameter int N_CH_WIDE = 3,
    parameter int N_CH_NARR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              load_auto,
    input  logic              step,
    input  logic              var_three,
    output logic [CH_W-1:0]   chan
);

    localparam logic [CH_W-1:0] LAST_WIDE = CH_W'(N_CH_WIDE - 1);
    localparam logic [CH_W-1:0] LAST_NARR = CH_W'(N_CH_NARR - 1);

    logic            auto_q;
    logic [CH_W-1:0] last_ch;
    logic [CH_W-1:0] chan_adv;

    always_comb begin
        last_ch  = var_three ? LAST_WIDE : LAST_NARR;
        chan_adv = (chan == last_ch) ? '0 : chan + CH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan   <= '0;
            auto_q <= 1'b0;
        end else if (load) begin
            auto_q <= load_auto;
            chan   <= load_auto ? '0 : CH_W'(load_code);
        end else if (step && auto_q) begin
            chan <= chan_adv;
        end
    end

endmodule

// File: rtl/scd_fsm.sv
`timescale 1ns/1ps
module scd_fsm
    import scd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic cmd_lim,
    input  logic cmd_rd,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic bus_stop,
    input  logic word_ack,
    input  logic conv_done,
    output logic step,
    output logic cmd_ack,
    output logic sample_en,
    output logic conv_start,
    output logic rd_shift,
    output logic lim_access,
    output logic lim_write,
    output logic monitor_on
);

    seq_state_e state, state_nx;
    logic       lim_q;
    logic       rd_q;

    // state register and latched command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lim_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lim_q <= cmd_lim;
                rd_q  <= cmd_rd;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (accept) begin
            state_nx = ST_ACK;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_ACK: begin
                    if (bus_stop)      state_nx = ST_IDLE;
                    else if (scl_fall) state_nx = lim_q ? ST_XFER : (rd_q ? ST_GAP : ST_MSAMP);
                end
                ST_GAP: begin
                    if (bus_stop)      state_nx = ST_IDLE;
                    else if (scl_rise) state_nx = ST_XFER;
                end
                ST_XFER: begin
                    if (bus_stop)                        state_nx = ST_IDLE;
                    else if (word_ack && !lim_q && rd_q) state_nx = ST_RESAMP;
                end
                ST_RESAMP: begin
                    if (bus_stop)      state_nx = ST_IDLE;
                    else if (scl_fall) state_nx = ST_GAP;
                end
                ST_MSAMP:  state_nx = ST_MCONV;
                ST_MCONV: begin
                    if (conv_done)     state_nx = ST_MSAMP;
                end
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ack    = (state == ST_ACK);
        sample_en  = ((state == ST_ACK) && !lim_q) || (state == ST_GAP) ||
                     (state == ST_RESAMP) || (state == ST_MSAMP);
        conv_start = ((state == ST_GAP) && (state_nx == ST_XFER)) || (state == ST_MSAMP);
        rd_shift   = (state == ST_XFER) && rd_q && scl_fall;
        lim_access = (state == ST_XFER) && lim_q;
        lim_write  = (state == ST_XFER) && lim_q && !rd_q;
        monitor_on = (state == ST_MSAMP) || (state == ST_MCONV);
        step       = ((state == ST_XFER) && (state_nx == ST_RESAMP)) ||
                     ((state == ST_MCONV) && (state_nx == ST_MSAMP));
    end

endmodule

// File: rtl/scd_top.sv
`timescale 1ns/1ps
module scd_top
    import scd_pkg::*;
#(
    parameter int CH_W      = 2,
    parameter int N_CH_WIDE = 3,
    parameter int N_CH_NARR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_valid,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_stop,
    input  logic              word_ack,
    input  logic              conv_done,
    input  logic              var_three,
    input  logic              var_addr,
    input  logic [ID_W-2:0]   addr_pins,
    input  logic              ce_n,
    output logic              cmd_ack,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sample_en,
    output logic              conv_start,
    output logic              rd_shift,
    output logic              lim_access,
    output logic              lim_write,
    output logic              monitor_on
);

    logic        id_hit;
    logic        accept;
    logic        step;
    cmd_fields_t fields;

    assign accept = cmd_valid && id_hit;

    scd_decode u_decode (
        .cmd_byte  (cmd_byte),
        .var_addr  (var_addr),
        .addr_pins (addr_pins),
        .ce_n      (ce_n),
        .id_hit    (id_hit),
        .fields    (fields)
    );

    scd_chan_seq #(
        .CH_W      (CH_W),
        .N_CH_WIDE (N_CH_WIDE),
        .N_CH_NARR (N_CH_NARR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_code (fields.code),
        .load_auto (fields.auto_req),
        .step      (step),
        .var_three (var_three),
        .chan      (mux_sel)
    );

    scd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cmd_lim    (fields.lim),
        .cmd_rd     (fields.rd),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_stop   (bus_stop),
        .word_ack   (word_ack),
        .conv_done  (conv_done),
        .step       (step),
        .cmd_ack    (cmd_ack),
        .sample_en  (sample_en),
        .conv_start (conv_start),
        .rd_shift   (rd_shift),
        .lim_access (lim_access),
        .lim_write  (lim_write),
        .monitor_on (monitor_on)
    );

endmodule

// File: rtl/scd_checks.sv
`timescale 1ns/1ps
module scd_checks #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            scl_fall,
    input logic            bus_stop,
    input logic            word_ack,
    input logic            conv_done,
    input logic            cmd_ack,
    input logic [CH_W-1:0] mux_sel,
    input logic            sample_en,
    input logic            conv_start,
    input logic            rd_shift,
    input logic            lim_access,
    input logic            lim_write,
    input logic            monitor_on
);

    assert_ack_from_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ack) |-> $past(cmd_valid))
        else $error("ack rose without a command byte");

    assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack && !scl_fall && !bus_stop) |=> cmd_ack)
        else $error("ack dropped early");

    assert_mux_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !word_ack && !conv_done) |=> $stable(mux_sel))
        else $error("channel moved without a cause");

    assert_conv_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> sample_en)
        else $error("start outside sample window");

    assert_conv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start)
        else $error("start longer than one cycle");

    assert_shift_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_shift |-> (scl_fall && !lim_write))
        else $error("shift without falling edge or during write");

    assert_lim_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lim_access |-> (!sample_en && !conv_start && !monitor_on))
        else $error("sampler active during limit access");

    assert_lim_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lim_write |-> lim_access)
        else $error("write flag outside limit access");

    assert_mon_persist_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_on && !cmd_valid) |=> monitor_on)
        else $error("monitoring ended without a command");

endmodule

bind scd_top scd_checks #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .scl_fall   (scl_fall),
    .bus_stop   (bus_stop),
    .word_ack   (word_ack),
    .conv_done  (conv_done),
    .cmd_ack    (cmd_ack),
    .mux_sel    (mux_sel),
    .sample_en  (sample_en),
    .conv_start (conv_start),
    .rd_shift   (rd_shift),
    .lim_access (lim_access),
    .lim_write  (lim_write),
    .monitor_on (monitor_on)
);

// File: tb/scd_top_tb.sv
`timescale 1ns/1ps
module scd_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_valid = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0, bus_stop = 1'b0;
    logic       word_ack = 1'b0, conv_done = 1'b0;
    logic       var_three = 1'b1, var_addr = 1'b0, ce_n = 1'b1;
    logic [2:0] addr_pins = 3'b000;
    logic       cmd_ack, sample_en, conv_start, rd_shift, lim_access, lim_write, monitor_on;
    logic [1:0] mux_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    scd_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_stop(bus_stop),
        .word_ack(word_ack), .conv_done(conv_done), .var_three(var_three),
        .var_addr(var_addr), .addr_pins(addr_pins), .ce_n(ce_n),
        .cmd_ack(cmd_ack), .mux_sel(mux_sel), .sample_en(sample_en),
        .conv_start(conv_start), .rd_shift(rd_shift), .lim_access(lim_access),
        .lim_write(lim_write), .monitor_on(monitor_on)
    );

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_ACK = 1, M_GAP = 2, M_XFER = 3, M_RES = 4, M_MS = 5, M_MC = 6;
    int m_st = M_IDLE, m_lim = 0, m_rd = 0, m_auto = 0, m_ch = 0;

    function automatic bit ident_ok();
        logic [3:0] want;
        want = var_addr ? {addr_pins, 1'b1} : 4'b1001;
        return (cmd_byte[7:4] == want) && (!var_addr || !ce_n);
    endfunction

    function automatic int model_next();
        if (cmd_valid && ident_ok()) return M_ACK;
        case (m_st)
            M_ACK:  if (bus_stop) return M_IDLE;
                    else if (scl_fall) return (m_lim != 0) ? M_XFER : ((m_rd != 0) ? M_GAP : M_MS);
            M_GAP:  if (bus_stop) return M_IDLE; else if (scl_rise) return M_XFER;
            M_XFER: if (bus_stop) return M_IDLE;
                    else if (word_ack && m_lim == 0 && m_rd != 0) return M_RES;
            M_RES:  if (bus_stop) return M_IDLE; else if (scl_fall) return M_GAP;
            M_MS:   return M_MC;
            M_MC:   if (conv_done) return M_MS;
            default: ;
        endcase
        return m_st;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_lim = 0; m_rd = 0; m_auto = 0; m_ch = 0;
        end else begin
            int nx;
            nx = model_next();
            if (cmd_valid && ident_ok()) begin
                m_lim = cmd_byte[3]; m_rd = cmd_byte[0];
                m_auto = (!cmd_byte[3] && cmd_byte[2:1] == 2'b11) ? 1 : 0;
                m_ch = (m_auto != 0) ? 0 : int'(cmd_byte[2:1]);
            end else if (((m_st == M_XFER && nx == M_RES) || (m_st == M_MC && nx == M_MS)) && m_auto != 0) begin
                m_ch = (m_ch == (var_three ? 2 : 1)) ? 0 : m_ch + 1;
            end
            m_st = nx;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_lim;
            e_lim = (m_st == M_XFER && m_lim != 0) ? 1 : 0;
            chk(cmd_ack,    m_st == M_ACK, "R2 model cmd_ack");
            chk(mux_sel,    m_ch, "R3 model mux_sel");
            chk(sample_en,  (m_st == M_ACK && m_lim == 0) || m_st == M_GAP || m_st == M_RES || m_st == M_MS, "R6 model sample_en");
            chk(conv_start, (m_st == M_GAP && model_next() == M_XFER) || m_st == M_MS, "R6 model conv_start");
            chk(rd_shift,   m_st == M_XFER && m_rd != 0 && scl_fall, "R7 model rd_shift");
            chk(lim_access, e_lim, "R9 model lim_access");
            chk(lim_write,  e_lim != 0 && m_rd == 0, "R9 model lim_write");
            chk(monitor_on, m_st == M_MS || m_st == M_MC, "R10 model monitor_on");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input int which, input logic v);
        case (which)
            0: cmd_valid = v;
            1: scl_rise  = v;
            2: scl_fall  = v;
            3: bus_stop  = v;
            4: word_ack  = v;
            default: conv_done = v;
        endcase
    endtask

    task automatic fire(input int which);
        @(posedge clk); #1 drive(which, 1'b1);
        @(posedge clk); #1 drive(which, 1'b0);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1 cmd_byte = b;
        fire(0);
    endtask

    task automatic rise_checked(input string tag);
        @(posedge clk); #1 scl_rise = 1'b1;
        @(negedge clk); chk(conv_start, 1, tag);
        @(posedge clk); #1 scl_rise = 1'b0;
        @(negedge clk); chk(sample_en, 0, tag);
    endtask

    task automatic fall_checked(input int exp_shift, input string tag);
        @(posedge clk); #1 scl_fall = 1'b1;
        @(negedge clk); chk(rd_shift, exp_shift, tag);
        @(posedge clk); #1 scl_fall = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R12: actual hung expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(cmd_ack, 0, "R12"); chk(mux_sel, 0, "R12"); chk(sample_en, 0, "R12");
        chk(conv_start, 0, "R12"); chk(monitor_on, 0, "R12"); chk(lim_access, 0, "R12");

        // R1 wrong identity ignored
        send(8'hA3);
        chk(cmd_ack, 0, "R1"); chk(mux_sel, 0, "R1"); chk(sample_en, 0, "R1");

        // single conversion on channel 1
        send(8'h93);
        chk(cmd_ack, 1, "R2"); chk(mux_sel, 1, "R3"); chk(sample_en, 1, "R6");
        fire(2);
        chk(cmd_ack, 0, "R2"); chk(sample_en, 1, "R6");
        rise_checked("R6");
        fall_checked(1, "R7");
        fire(3);
        chk(sample_en, 0, "R11"); chk(monitor_on, 0, "R11"); chk(rd_shift, 0, "R11");

        // repeated conversions on channel 2
        send(8'h95);
        fire(2); rise_checked("R8");
        fire(4); chk(mux_sel, 2, "R8"); chk(sample_en, 1, "R8");
        fire(2); rise_checked("R8");
        fire(4); chk(mux_sel, 2, "R8");
        fire(3);

        // auto-increment, three channels
        send(8'h97);
        chk(mux_sel, 0, "R4");
        fire(2); rise_checked("R4");
        fire(4); chk(mux_sel, 1, "R5");
        fire(2); rise_checked("R5");
        fire(4); chk(mux_sel, 2, "R5");
        fire(2); rise_checked("R5");
        fire(4); chk(mux_sel, 0, "R5");
        fire(3);

        // auto-increment, two channels
        var_three = 1'b0;
        send(8'h97);
        fire(2); rise_checked("R5");
        fire(4); chk(mux_sel, 1, "R5");
        fire(2); rise_checked("R5");
        fire(4); chk(mux_sel, 0, "R5");
        fire(3);
        var_three = 1'b1;

        // limit write then limit read
        send(8'h9A);
        chk(sample_en, 0, "R9");
        fire(2);
        chk(lim_access, 1, "R9"); chk(lim_write, 1, "R9"); chk(mux_sel, 1, "R9");
        fire(4); chk(mux_sel, 1, "R9"); chk(lim_access, 1, "R9");
        fire(3);
        send(8'h99);
        fire(2);
        chk(lim_write, 0, "R9");
        fall_checked(1, "R7");
        fire(3);

        // autonomous monitoring with auto-increment
        send(8'h96);
        fire(2);
        chk(monitor_on, 1, "R10"); chk(conv_start, 1, "R10");
        @(posedge clk); @(negedge clk);
        chk(conv_start, 0, "R10"); chk(sample_en, 0, "R10");
        fire(5); chk(mux_sel, 1, "R10");
        fire(5); chk(mux_sel, 2, "R10");
        fire(5); chk(mux_sel, 0, "R10");
        fire(3); chk(monitor_on, 1, "R10");
        send(8'hA6); chk(monitor_on, 1, "R1"); chk(cmd_ack, 0, "R1");
        send(8'h93); chk(monitor_on, 0, "R10"); chk(cmd_ack, 1, "R10");
        fire(3);

        // addressable variant
        var_addr = 1'b1; addr_pins = 3'b101; ce_n = 1'b1;
        send(8'hB1); chk(cmd_ack, 0, "R1");
        ce_n = 1'b0;
        send(8'h91); chk(cmd_ack, 0, "R1");
        send(8'hB3); chk(cmd_ack, 1, "R1"); chk(mux_sel, 1, "R1");
        fire(3);

        repeat (4) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule